// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

This block links an A bus to a B bus through a set of independent byte-wide channels. Two are the default, so together they form one 16-bit transceiver. Each channel has a storage register for each direction. The A-side register loads from the A pins, and the B-side register loads from the B pins. For each direction, a select input decides whether the far port shows live data or the stored byte. A separate enable per direction gates that port's drivers. The A-to-B enable is active high. The B-to-A enable is active low.

Pads are modelled as separate input, output and output-enable vectors, so the block contains no tristate logic. The direction clocks are treated as asynchronous strobes. Each is synchronised through two flops and edge-detected on the single system clock. Each channel runs a five-state controller, decoded from its enables and selects once per system cycle:

- `ST_ISOLATE`: neither port drives.
- `ST_DRIVE_B`: only B drives.
- `ST_DRIVE_A`: only A drives.
- `ST_DRIVE_BOTH`: both ports drive, with at least one direction showing stored data.
- `ST_LOOP_HOLD`: both ports drive live data, so each reinforces the other.

Any state moves to any other on the next system edge, following the decoded inputs. A move into `ST_LOOP_HOLD` latches the hold value. A move out of it releases the hold value.

Outputs are registered. Live data therefore appears one system cycle after the resolved source pins, and every change of output source takes effect on a single clock edge.

Top module: `xcvr_dual_top`

## Requirements
- R1: Each channel (byte c = bits 8c+7..8c) has its own two clocks, two selects and two enables, and no channel's controls affect another channel's outputs.
- R2: A rising edge on a channel's A-to-B clock loads that channel's A register from its resolved A pins, and a B-to-A clock edge loads the B register from the resolved B pins. The load completes within three system cycles and happens whatever the select and enable levels are.
- R3: With the A-to-B select low (live), the B output equals the resolved A pins of the previous system cycle. Likewise, with the B-to-A select low, the A output equals the resolved B pins of the previous cycle. The resolved pin value is the block's own output where that port drives, and the external input otherwise.
- R4: With a select high (stored), the corresponding output carries that direction's register, and it stays unchanged while no load occurs.
- R5: One cycle after the inputs, every bit of the B output-enable equals the A-to-B enable (active high), and every bit of the A output-enable equals the inverse of the B-to-A enable (active low).
- R6: A-to-B enable low together with B-to-A enable high gives isolation (state `ST_ISOLATE`), in which neither port drives.
- R7: While a port drives, its register captures the driven value, so the same byte can be stored in both registers.
- R8: With both selects low and both ports enabled (state `ST_LOOP_HOLD`), the resolved A pin value of the entry cycle is latched. Both ports then drive that value, whatever the external inputs are, until the state is left.
- R9: Switching a select between live and stored changes the output in one system edge, directly from the old source's value to the new one.
- R10: The active-low synchronous reset clears the registers, outputs and output enables to zero and places each channel in `ST_ISOLATE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a2b_clk | input | N_CH | Per-channel A-register load strobe, asynchronous |
| b2a_clk | input | N_CH | Per-channel B-register load strobe, asynchronous |
| a2b_sel | input | N_CH | Per-channel B-output source: 0 live A, 1 stored A |
| b2a_sel | input | N_CH | Per-channel A-output source: 0 live B, 1 stored B |
| a2b_en | input | N_CH | Per-channel B-port drive enable, active high |
| b2a_en_n | input | N_CH | Per-channel A-port drive enable, active low |
| a_pin_i | input | CH_W*N_CH | Value from the external A bus |
| a_pin_o | output | CH_W*N_CH | Value driven onto the A bus |
| a_pin_oe | output | CH_W*N_CH | Per-bit A drive enable |
| b_pin_i | input | CH_W*N_CH | Value from the external B bus |
| b_pin_o | output | CH_W*N_CH | Value driven onto the B bus |
| b_pin_oe | output | CH_W*N_CH | Per-bit B drive enable |

## Verification
The bound checker verifies the following on every cycle:

- Each output enable follows its control input with one cycle of delay.
- Isolation produces no drive.
- A live output equals the previous cycle's resolved source pins.
- A stored output stays still while no load strobe has been seen.
- In the hold loop, both ports carry one unchanging value.
- Reset clears all outputs.

Only the bench scenarios can show the following:

- A strobe actually lands the right byte in a register.
- A driven value reaches both registers.
- The hold value is the one seen at loop entry.
- Channels stay independent.
- A select switch moves the output in exactly one step.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [2:0] {
        ST_ISOLATE    = 3'd0,
        ST_DRIVE_B    = 3'd1,
        ST_DRIVE_A    = 3'd2,
        ST_DRIVE_BOTH = 3'd3,
        ST_LOOP_HOLD  = 3'd4
    } xfer_state_e;

    // Map one channel's enables and selects to its transfer state.
    function automatic xfer_state_e decode_state(
        input logic en_ab,
        input logic en_ba_n,
        input logic sel_ab,
        input logic sel_ba
    );
        xfer_state_e st;
        if (en_ab && !en_ba_n) begin
            st = (!sel_ab && !sel_ba) ? ST_LOOP_HOLD : ST_DRIVE_BOTH;
        end else if (en_ab) begin
            st = ST_DRIVE_B;
        end else if (!en_ba_n) begin
            st = ST_DRIVE_A;
        end else begin
            st = ST_ISOLATE;
        end
        return st;
    endfunction

endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/xcvr_ctrl_fsm.sv
module xcvr_ctrl_fsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_ab,
    input  logic en_ba_n,
    input  logic sel_ab,
    input  logic sel_ba,
    output logic a_drive,
    output logic b_drive,
    output logic loop_enter,
    output logic loop_active
);
    xfer_state_e state_q;
    xfer_state_e state_d;

    assign state_d = decode_state(en_ab, en_ba_n, sel_ab, sel_ba);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ISOLATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs of the current state
    always_comb begin
        a_drive     = 1'b0;
        b_drive     = 1'b0;
        loop_active = 1'b0;
        unique case (state_q)
            ST_ISOLATE: begin
            end
            ST_DRIVE_B: begin
                b_drive = 1'b1;
            end
            ST_DRIVE_A: begin
                a_drive = 1'b1;
            end
            ST_DRIVE_BOTH: begin
                a_drive = 1'b1;
                b_drive = 1'b1;
            end
            ST_LOOP_HOLD: begin
                a_drive     = 1'b1;
                b_drive     = 1'b1;
                loop_active = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Asserted on the cycle before the controller enters the hold loop.
    assign loop_enter = (state_d == ST_LOOP_HOLD) && (state_q != ST_LOOP_HOLD);
endmodule

// File: rtl/xcvr_chan_path.sv
module xcvr_chan_path #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_load,
    input  logic            b_load,
    input  logic            sel_ab,
    input  logic            sel_ba,
    input  logic            a_drive,
    input  logic            b_drive,
    input  logic            loop_enter,
    input  logic            loop_stay,
    input  logic [CH_W-1:0] a_pin_i,
    input  logic [CH_W-1:0] b_pin_i,
    output logic [CH_W-1:0] a_out,
    output logic [CH_W-1:0] b_out
);
    logic [CH_W-1:0] a_res;
    logic [CH_W-1:0] b_res;
    logic [CH_W-1:0] a_store_q;
    logic [CH_W-1:0] b_store_q;
    logic [CH_W-1:0] a_q;
    logic [CH_W-1:0] b_q;

    // Resolved pin value: own drive where enabled, external input otherwise.
    assign a_res = a_drive ? a_q : a_pin_i;
    assign b_res = b_drive ? b_q : b_pin_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_store_q <= '0;
            b_store_q <= '0;
        end else begin
            if (a_load) a_store_q <= a_res;
            if (b_load) b_store_q <= b_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (loop_enter) begin
            a_q <= a_res;
            b_q <= a_res;
        end else if (!loop_stay) begin
            b_q <= sel_ab ? a_store_q : a_res;
            a_q <= sel_ba ? b_store_q : b_res;
        end
    end

    assign a_out = a_q;
    assign b_out = b_q;
endmodule

// File: rtl/xcvr_dual_top.sv
module xcvr_dual_top #(
    parameter int CH_W     = 8,
    parameter int N_CH     = 2,
    parameter int SYNC_LEN = 2,
    localparam int BUS_W   = CH_W * N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  a2b_clk,
    input  logic [N_CH-1:0]  b2a_clk,
    input  logic [N_CH-1:0]  a2b_sel,
    input  logic [N_CH-1:0]  b2a_sel,
    input  logic [N_CH-1:0]  a2b_en,
    input  logic [N_CH-1:0]  b2a_en_n,
    input  logic [BUS_W-1:0] a_pin_i,
    output logic [BUS_W-1:0] a_pin_o,
    output logic [BUS_W-1:0] a_pin_oe,
    input  logic [BUS_W-1:0] b_pin_i,
    output logic [BUS_W-1:0] b_pin_o,
    output logic [BUS_W-1:0] b_pin_oe
);
    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        logic a_rise, b_rise;
        logic a_drv, b_drv, enter, stay;

        xcvr_edge_sync #(.STAGES(SYNC_LEN)) u_sync_ab (
            .clk(clk), .rst_n(rst_n), .strobe_i(a2b_clk[c]), .rise_o(a_rise)
        );
        xcvr_edge_sync #(.STAGES(SYNC_LEN)) u_sync_ba (
            .clk(clk), .rst_n(rst_n), .strobe_i(b2a_clk[c]), .rise_o(b_rise)
        );

        xcvr_ctrl_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .en_ab(a2b_en[c]), .en_ba_n(b2a_en_n[c]),
            .sel_ab(a2b_sel[c]), .sel_ba(b2a_sel[c]),
            .a_drive(a_drv), .b_drive(b_drv),
            .loop_enter(enter), .loop_active(stay)
        );

        xcvr_chan_path #(.CH_W(CH_W)) u_path (
            .clk(clk), .rst_n(rst_n),
            .a_load(a_rise), .b_load(b_rise),
            .sel_ab(a2b_sel[c]), .sel_ba(b2a_sel[c]),
            .a_drive(a_drv), .b_drive(b_drv),
            .loop_enter(enter), .loop_stay(stay),
            .a_pin_i(a_pin_i[c*CH_W +: CH_W]),
            .b_pin_i(b_pin_i[c*CH_W +: CH_W]),
            .a_out(a_pin_o[c*CH_W +: CH_W]),
            .b_out(b_pin_o[c*CH_W +: CH_W])
        );

        assign a_pin_oe[c*CH_W +: CH_W] = {CH_W{a_drv}};
        assign b_pin_oe[c*CH_W +: CH_W] = {CH_W{b_drv}};
    end
endmodule

// File: rtl/xcvr_dual_chk.sv
module xcvr_dual_chk #(
    parameter int CH_W     = 8,
    parameter int N_CH     = 2,
    localparam int BUS_W   = CH_W * N_CH
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_CH-1:0]  a2b_clk,
    input logic [N_CH-1:0]  b2a_clk,
    input logic [N_CH-1:0]  a2b_sel,
    input logic [N_CH-1:0]  b2a_sel,
    input logic [N_CH-1:0]  a2b_en,
    input logic [N_CH-1:0]  b2a_en_n,
    input logic [BUS_W-1:0] a_pin_i,
    input logic [BUS_W-1:0] a_pin_o,
    input logic [BUS_W-1:0] a_pin_oe,
    input logic [BUS_W-1:0] b_pin_i,
    input logic [BUS_W-1:0] b_pin_o,
    input logic [BUS_W-1:0] b_pin_oe
);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (a_pin_o == '0 && b_pin_o == '0 && a_pin_oe == '0 && b_pin_oe == '0));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        logic loop_req;
        assign loop_req = a2b_en[c] && !b2a_en_n[c] && !a2b_sel[c] && !b2a_sel[c];

        // R5
        en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |->
                (b_pin_oe[c*CH_W +: CH_W] == {CH_W{$past(a2b_en[c])}}) &&
                (a_pin_oe[c*CH_W +: CH_W] == {CH_W{!$past(b2a_en_n[c])}}));

        // R6
        isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!a2b_en[c] && b2a_en_n[c])) |->
                (a_pin_oe[c*CH_W +: CH_W] == '0 && b_pin_oe[c*CH_W +: CH_W] == '0));

        // R3
        live_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!a2b_sel[c]) && !$past(loop_req)) |->
                b_pin_o[c*CH_W +: CH_W] ==
                $past(a_pin_oe[c*CH_W] ? a_pin_o[c*CH_W +: CH_W] : a_pin_i[c*CH_W +: CH_W]));

        // R3
        live_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!b2a_sel[c]) && !$past(loop_req)) |->
                a_pin_o[c*CH_W +: CH_W] ==
                $past(b_pin_oe[c*CH_W] ? b_pin_o[c*CH_W +: CH_W] : b_pin_i[c*CH_W +: CH_W]));

        // R4
        stored_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(a2b_sel[c]) && $past(a2b_sel[c], 2) &&
             !$past(a2b_clk[c]) && !$past(a2b_clk[c], 2) &&
             !$past(a2b_clk[c], 3) && !$past(a2b_clk[c], 4)) |->
                $stable(b_pin_o[c*CH_W +: CH_W]));

        // R4
        stored_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(b2a_sel[c]) && $past(b2a_sel[c], 2) &&
             !$past(b2a_clk[c]) && !$past(b2a_clk[c], 2) &&
             !$past(b2a_clk[c], 3) && !$past(b2a_clk[c], 4)) |->
                $stable(a_pin_o[c*CH_W +: CH_W]));

        // R8
        loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2) && $past(loop_req) && $past(loop_req, 2)) |->
                ($stable(a_pin_o[c*CH_W +: CH_W]) &&
                 a_pin_o[c*CH_W +: CH_W] == b_pin_o[c*CH_W +: CH_W]));
    end
endmodule

bind xcvr_dual_top xcvr_dual_chk #(.CH_W(CH_W), .N_CH(N_CH)) u_dual_chk (
    .clk(clk), .rst_n(rst_n),
    .a2b_clk(a2b_clk), .b2a_clk(b2a_clk),
    .a2b_sel(a2b_sel), .b2a_sel(b2a_sel),
    .a2b_en(a2b_en), .b2a_en_n(b2a_en_n),
    .a_pin_i(a_pin_i), .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe),
    .b_pin_i(b_pin_i), .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe)
);

// File: tb/test_xcvr_dual_top.sv
`timescale 1ns/1ps
module test_xcvr_dual_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  a2b_clk = '0, b2a_clk = '0, a2b_sel = '0, b2a_sel = '0;
    logic [1:0]  a2b_en = '0, b2a_en_n = 2'b11;
    logic [15:0] a_pin_i = '0, b_pin_i = '0;
    logic [15:0] a_pin_o, a_pin_oe, b_pin_o, b_pin_oe;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xcvr_dual_top i_xcvr_dual_top (
        .clk(clk), .rst_n(rst_n),
        .a2b_clk(a2b_clk), .b2a_clk(b2a_clk),
        .a2b_sel(a2b_sel), .b2a_sel(b2a_sel),
        .a2b_en(a2b_en), .b2a_en_n(b2a_en_n),
        .a_pin_i(a_pin_i), .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe),
        .b_pin_i(b_pin_i), .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe)
    );

    // Rows: {ctrl ch1, ctrl ch0, a_in, b_in}; ctrl = {a2b_en, b2a_en_n, a2b_sel, b2a_sel}
    localparam logic [39:0] VEC [0:7] = '{
        {4'b0100, 4'b0100, 16'h1234, 16'h5678},
        {4'b1100, 4'b1100, 16'hA5C3, 16'h0F0F},
        {4'b0000, 4'b0000, 16'hFFFF, 16'h8001},
        {4'b1100, 4'b0000, 16'h1357, 16'h9BDF},
        {4'b0000, 4'b1100, 16'h00FF, 16'hFF00},
        {4'b0100, 4'b1100, 16'h7E81, 16'h1111},
        {4'b1100, 4'b0100, 16'h0001, 16'h8000},
        {4'b0000, 4'b0100, 16'hAAAA, 16'h5555}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input int c, input logic [3:0] n);
        a2b_en[c]   = n[3];
        b2a_en_n[c] = n[2];
        a2b_sel[c]  = n[1];
        b2a_sel[c]  = n[0];
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int c, input bit ab);
        @(negedge clk);
        if (ab) a2b_clk[c] = 1'b1; else b2a_clk[c] = 1'b1;
        wait_cyc(2);
        if (ab) a2b_clk[c] = 1'b0; else b2a_clk[c] = 1'b0;
        wait_cyc(5);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 out", a_pin_o | b_pin_o, 16'h0000);
        chk("R10 oe", a_pin_oe | b_pin_oe, 16'h0000);

        // Table walk: R3, R5, R6, R1
        for (int i = 0; i < 8; i++) begin
            logic [3:0]  n1, n0;
            logic [15:0] am, bm;
            n1 = VEC[i][39:36];
            n0 = VEC[i][35:32];
            @(negedge clk);
            set_ctrl(1, n1);
            set_ctrl(0, n0);
            a_pin_i = VEC[i][31:16];
            b_pin_i = VEC[i][15:0];
            wait_cyc(3);
            am = {{8{!n1[2]}}, {8{!n0[2]}}};
            bm = {{8{n1[3]}}, {8{n0[3]}}};
            chk("R5/R6 a_oe", a_pin_oe, am);
            chk("R5/R6 b_oe", b_pin_oe, bm);
            chk("R3/R1 a_out", a_pin_o & am, b_pin_i & am);
            chk("R3/R1 b_out", b_pin_o & bm, a_pin_i & bm);
        end

        // R2/R4: capture while isolated with selects high
        @(negedge clk);
        set_ctrl(0, 4'b0111);
        set_ctrl(1, 4'b0100);
        a_pin_i = 16'h005A;
        b_pin_i = 16'h003C;
        pulse(0, 1'b1);
        pulse(0, 1'b0);
        a_pin_i = 16'h0011;
        b_pin_i = 16'h0022;
        set_ctrl(0, 4'b1011);
        wait_cyc(3);
        chk("R2/R4 b stored", b_pin_o[7:0], 16'h005A);
        chk("R2/R4 a stored", a_pin_o[7:0], 16'h003C);
        chk("R1 ch1 idle", a_pin_oe[15:8] | b_pin_oe[15:8], 16'h0000);

        // R9: stored -> live switch in one step
        set_ctrl(0, 4'b1110);
        wait_cyc(3);
        chk("R9 before", b_pin_o[7:0], 16'h005A);
        a2b_sel[0] = 1'b0;
        @(negedge clk);
        chk("R9 step1", b_pin_o[7:0], 16'h0011);
        @(negedge clk);
        chk("R9 step2", b_pin_o[7:0], 16'h0011);

        // R7: ch1 A drives live B; store that byte in both registers
        set_ctrl(1, 4'b0000);
        a_pin_i[15:8] = 8'h00;
        b_pin_i[15:8] = 8'hC3;
        wait_cyc(3);
        pulse(1, 1'b1);
        pulse(1, 1'b0);
        b_pin_i[15:8] = 8'h00;
        set_ctrl(1, 4'b1011);
        wait_cyc(3);
        chk("R7 a_out", a_pin_o[15:8], 16'h00C3);
        chk("R7 b_out", b_pin_o[15:8], 16'h00C3);

        // R8: hold loop on ch0
        set_ctrl(0, 4'b1100);
        a_pin_i[7:0] = 8'h3C;
        wait_cyc(3);
        set_ctrl(0, 4'b1000);
        wait_cyc(2);
        a_pin_i[7:0] = 8'hF0;
        b_pin_i[7:0] = 8'h0F;
        wait_cyc(4);
        chk("R8 a_out", a_pin_o[7:0], 16'h003C);
        chk("R8 b_out", b_pin_o[7:0], 16'h003C);
        chk("R8 oe", {a_pin_oe[7:0], b_pin_oe[7:0]}, 16'hFFFF);
        chk("R1 ch1 kept", b_pin_o[15:8], 16'h00C3);
        pulse(0, 1'b1);
        set_ctrl(0, 4'b1110);
        wait_cyc(3);
        chk("R7/R8 held captured", b_pin_o[7:0], 16'h003C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule